// File: doc/BRIEF.md
# Two-Channel Extended-Resolution PWM Generator

This block drives two pulse-width-modulated outputs whose average duty reaches 10-bit resolution while each channel only holds an 8-bit duty value. Time is measured in count-source ticks (`cnt_tick`). A short interval is 256 ticks long. Each output goes high at the start of the interval and stays high for `n` ticks, where `n` is that channel's duty value.

Four short intervals form one long interval. A 2-bit stretch value `e` lengthens the first `e` pulses of every long interval by one tick. The mean high time is therefore (4n+e)/4 ticks per short interval. Both channels share the same stretch value.

Duty values and the stretch value are captured only at long-interval boundaries, so software may write them at any time without producing a runt pulse. A one-cycle strobe marks the start of each long interval. Clearing the enable stops the timebase and forces both outputs low.

Top module: `pwm10_top`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is all zero and `long_start` is low.
- R2: On a clock edge where `run_en` is low, the timebase stops: in the following cycle `pwm_out` is zero and `long_start` is low. The next tick with `run_en` high starts a new long interval.
- R3: A short interval lasts 256 ticks. In it each channel goes high at tick offset 0 and is high for exactly its width in ticks. Each short interval holds exactly one pulse.
- R4: A long interval is four short intervals (1024 ticks). `long_start` is high for one clock cycle after the tick that opens a long interval, and never in two consecutive cycles.
- R5: With stretch value e (0..3), the pulses in short intervals 0..e-1 of a long interval have width n+1 ticks, and the rest have width n ticks.
- R6: Duty values (`duty_flat` bits [8c+7:8c] for channel c) and `ext_sel` are sampled only at the tick that opens a long interval. Changes at any other time have no effect until the next long interval.
- R7: With n=0 and e=0 the output stays low for the whole long interval. With n=0 and e>0, the first e short intervals each carry a one-tick pulse.
- R8: With n=255 and e>0, the stretched short intervals are high for all 256 ticks.
- R9: A clock cycle with `cnt_tick` low leaves the timebase and outputs unchanged.
- R10: The two channels are independent in width and share one stretch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-source enable, one tick per high cycle |
| run_en | input | 1 | Generator enable |
| duty_flat | input | 16 | Duty value per channel, channel c in bits [8c+7:8c] |
| ext_sel | input | 2 | Number of stretched pulses per long interval |
| pwm_out | output | 2 | PWM outputs, bit c for channel c |
| long_start | output | 1 | One-cycle strobe at each long-interval start |

## Verification
The embedded properties check the following on every cycle:
- the enable forces the outputs quiet;
- the strobe lines up with the timebase origin and never lasts two cycles;
- a pulse that has ended does not restart inside its short interval;
- latched duty values move only on a load;
- a cycle without a tick leaves the outputs stable.

The exact pulse widths, the stretch count per long interval, the deferred effect of mid-interval writes and the n=0 and n=255 corners need the bench's reference model and its high-time measurements. These run with ticks on every cycle and with sparse ticks.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int unsigned DEF_CNT_W = 8;
  localparam int unsigned DEF_EXT_W = 2;
  localparam int unsigned DEF_NCH   = 2;

  typedef enum logic {TB_IDLE = 1'b0, TB_RUN = 1'b1} tb_state_e;
endpackage

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned EXT_W = DEF_EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             run_en,
  input  logic [EXT_W-1:0] ext_sel,
  output logic             running,
  output logic [CNT_W-1:0] pos,
  output logic [EXT_W-1:0] slot,
  output logic [EXT_W-1:0] ext_lat,
  output logic             load,
  output logic             long_start
);
  localparam logic [CNT_W-1:0] POS_LAST  = {CNT_W{1'b1}};
  localparam logic [EXT_W-1:0] SLOT_LAST = {EXT_W{1'b1}};

  tb_state_e        state_q, state_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [EXT_W-1:0] slot_q, slot_d;
  logic [EXT_W-1:0] ext_q, ext_d;
  logic             strobe_q, strobe_d;
  logic             wrap_long;

  assign wrap_long = (pos_q == POS_LAST) && (slot_q == SLOT_LAST);
  assign load      = run_en && cnt_tick && ((state_q == TB_IDLE) || wrap_long);

  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    slot_d   = slot_q;
    ext_d    = ext_q;
    strobe_d = 1'b0;
    if (!run_en) begin
      state_d = TB_IDLE;
      pos_d   = '0;
      slot_d  = '0;
    end else if (cnt_tick) begin
      if (load) begin
        state_d  = TB_RUN;
        pos_d    = '0;
        slot_d   = '0;
        ext_d    = ext_sel;
        strobe_d = 1'b1;
      end else if (pos_q == POS_LAST) begin
        pos_d  = '0;
        slot_d = slot_q + 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TB_IDLE;
      pos_q    <= '0;
      slot_q   <= '0;
      ext_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pos_q    <= pos_d;
      slot_q   <= slot_d;
      ext_q    <= ext_d;
      strobe_q <= strobe_d;
    end
  end

  assign running    = (state_q == TB_RUN);
  assign pos        = pos_q;
  assign slot       = slot_q;
  assign ext_lat    = ext_q;
  assign long_start = strobe_q;

  // R4: the strobe coincides with the origin of a long interval
  p_strobe_at_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    long_start |-> (running && pos == '0 && slot == '0));

  // R4: the strobe never lasts two cycles
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    long_start |=> !long_start);

  // R6: the stretch value changes only on a load
  p_ext_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ext_lat));
endmodule

// File: rtl/pwm10_channel.sv
module pwm10_channel
  import pwm10_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned EXT_W = DEF_EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run_en,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] duty,
  input  logic             running,
  input  logic [CNT_W-1:0] pos,
  input  logic [EXT_W-1:0] slot,
  input  logic [EXT_W-1:0] ext_lat,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] POS_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] duty_q, duty_d;
  logic [CNT_W:0]   width;
  logic             stretch;

  always_comb begin
    duty_d = duty_q;
    if (load) duty_d = duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  assign stretch = (slot < ext_lat);
  assign width   = {1'b0, duty_q} + {{CNT_W{1'b0}}, stretch};
  assign pwm     = running && ({1'b0, pos} < width);

  // R3: once low, the pulse does not return inside the same short interval
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pwm && run_en && cnt_tick && !load && pos != POS_LAST) |=> !pwm);

  // R6: the latched duty moves only on a load
  p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_q));
endmodule

// File: rtl/pwm10_top.sv
module pwm10_top
  import pwm10_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned EXT_W = DEF_EXT_W,
  parameter int unsigned NCH   = DEF_NCH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_tick,
  input  logic                 run_en,
  input  logic [NCH*CNT_W-1:0] duty_flat,
  input  logic [EXT_W-1:0]     ext_sel,
  output logic [NCH-1:0]       pwm_out,
  output logic                 long_start
);
  logic             running;
  logic [CNT_W-1:0] pos;
  logic [EXT_W-1:0] slot;
  logic [EXT_W-1:0] ext_lat;
  logic             load;

  pwm10_timebase #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .run_en(run_en),
    .ext_sel(ext_sel), .running(running), .pos(pos), .slot(slot),
    .ext_lat(ext_lat), .load(load), .long_start(long_start)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm10_channel #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(load), .run_en(run_en),
      .cnt_tick(cnt_tick), .duty(duty_flat[c*CNT_W +: CNT_W]),
      .running(running), .pos(pos), .slot(slot), .ext_lat(ext_lat),
      .pwm(pwm_out[c])
    );
  end

  // R2: a disabled edge leaves the outputs quiet in the next cycle
  p_disable_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pwm_out == '0 && !long_start));

  // R9: without a tick the outputs hold
  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_tick) |=> $stable(pwm_out));
endmodule

// File: tb/sim_pwm10_top.sv
module sim_pwm10_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_tick;
  logic        run_en;
  logic [15:0] duty_flat;
  logic [1:0]  ext_sel;
  logic [1:0]  pwm_out;
  logic        long_start;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int tick_div = 1;
  bit finished = 0;

  // reference model state
  bit     m_run;
  int     m_t;
  int     m_n0, m_n1, m_e;
  bit     m_str;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm10_top u0 (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .run_en(run_en),
    .duty_flat(duty_flat), .ext_sel(ext_sel), .pwm_out(pwm_out),
    .long_start(long_start)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_t <= 0; m_n0 <= 0; m_n1 <= 0; m_e <= 0; m_str <= 0;
    end else if (!run_en) begin
      m_run <= 0; m_t <= 0; m_str <= 0;
    end else if (cnt_tick) begin
      if (!m_run || m_t == 1023) begin
        m_run <= 1; m_t <= 0; m_str <= 1;
        m_n0 <= duty_flat[7:0]; m_n1 <= duty_flat[15:8]; m_e <= ext_sel;
      end else begin
        m_t <= m_t + 1; m_str <= 0;
      end
    end else begin
      m_str <= 0;
    end
  end

  function automatic bit exp_pwm(input int n);
    int w;
    w = n + (((m_t / 256) < m_e) ? 1 : 0);
    return m_run && ((m_t % 256) < w);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(pwm_out[0] == exp_pwm(m_n0), cur_req, "pwm0", pwm_out[0], exp_pwm(m_n0));
      check(pwm_out[1] == exp_pwm(m_n1), cur_req, "pwm1", pwm_out[1], exp_pwm(m_n1));
      check(long_start == m_str, cur_req, "long_start", long_start, m_str);
    end
  end

  initial begin
    int ph = 0;
    cnt_tick = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % tick_div;
      cnt_tick = (ph == 0);
    end
  end

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic measure_long(input int ch, input int exp, input string req);
    int hi = 0;
    while (long_start !== 1'b1) @(negedge clk);
    for (int i = 0; i < 1024; i++) begin
      if (pwm_out[ch]) hi++;
      @(negedge clk);
    end
    check(hi == exp, req, "high ticks per long interval", hi, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; duty_flat = 16'd0; ext_sel = 2'd0;
    cycles(3);
    cur_req = "R1";
    check(pwm_out == 2'b00, "R1", "pwm in reset", pwm_out, 0);
    check(long_start == 1'b0, "R1", "strobe in reset", long_start, 0);
    rst_n = 1'b1;

    cur_req = "R3";
    duty_flat = {8'd37, 8'd100}; ext_sel = 2'd0; run_en = 1'b1;
    measure_long(0, 400, "R3");
    cur_req = "R10";
    measure_long(1, 148, "R10");

    cur_req = "R5";
    duty_flat = {8'd10, 8'd100}; ext_sel = 2'd2;
    cycles(1);
    measure_long(0, 402, "R5");
    measure_long(1, 42, "R10");

    cur_req = "R8";
    duty_flat = {8'd255, 8'd255}; ext_sel = 2'd3;
    cycles(1);
    measure_long(0, 1023, "R8");

    cur_req = "R7";
    duty_flat = {8'd0, 8'd0}; ext_sel = 2'd0;
    cycles(1);
    measure_long(0, 0, "R7");
    ext_sel = 2'd1;
    cycles(1);
    measure_long(1, 1, "R7");

    cur_req = "R6";
    duty_flat = {8'd20, 8'd50}; ext_sel = 2'd1;
    while (long_start !== 1'b1) @(negedge clk);
    cycles(300);
    duty_flat = {8'd220, 8'd200}; ext_sel = 2'd3;
    cycles(100);
    measure_long(0, 803, "R6");

    cur_req = "R2";
    cycles(500);
    run_en = 1'b0;
    cycles(2);
    check(pwm_out == 2'b00, "R2", "pwm while disabled", pwm_out, 0);
    cycles(20);
    run_en = 1'b1;
    duty_flat = {8'd5, 8'd7}; ext_sel = 2'd0;
    measure_long(0, 28, "R2");

    cur_req = "R9";
    tick_div = 3;
    duty_flat = {8'd90, 8'd60}; ext_sel = 2'd1;
    cycles(3 * 2200);
    tick_div = 1;
    cycles(2100);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule